// File: doc/BRIEF.md
# SPI Flash Command Monitor

A passive observer for a byte-level SPI flash bus. It does not drive the bus. A front end, outside this block, deserialises the bits. It presents each transferred byte as a pair: the byte the host sent and the byte the flash returned, qualified by a one-cycle strobe. Alongside the pair it gives the chip-select level. The first host byte after the device is selected is decoded as an opcode. Later bytes are counted with a byte index that starts at 1 for the opcode. Depending on the command, those bytes are assembled into a 24-bit address, counted as payload or captured as identification or status bytes.

A command ends in one of two ways: its byte sequence completes, or the device is deselected. At that point the monitor emits one event record. The record carries a class code, the raw opcode, the address, a payload byte count, up to three response bytes, a misaligned-erase warning and a truncation flag. Opcodes outside the table produce an unknown-class event at once. When a command ends on its own while the device stays selected, the next byte is decoded as a fresh opcode. Debug and trace logic can use the records to build a per-transaction log of flash traffic.

Top module: `spi_flash_cmd_monitor`

## Requirements
- R1: After reset `ev_valid` is 0, and the first byte accepted with select high is decoded as an opcode.
- R2: Opcode 0x06 (write enable) produces a class-1 event with address, count and response 0. The monitor returns to idle at once, so the next selected byte is a new opcode.
- R3: For opcodes 0x03 (read), 0x02 (page program) and 0x20 (sector erase), host bytes at index 2, 3 and 4 form `ev_addr`, most significant byte first.
- R4: Sector erase completes by itself after byte 4. `ev_misalign` is 1 exactly when the address bits [11:0] are not all zero, that is, when the address is not a multiple of 4096.
- R5: Read counts the flash-returned bytes from index 5 onwards and reports that count when the device is deselected.
- R6: Page program counts host bytes from index 5 onwards. It completes by itself after the PAGE_BYTES-th data byte (256 by default), and otherwise ends at deselect with the count seen so far; the count never exceeds PAGE_BYTES.
- R7: Any opcode outside the table produces a class-9 event that carries the opcode, in the cycle after the byte. The monitor then returns to idle.
- R8: Deselect ends any command in progress. The event carries the fields gathered so far, and the byte index returns to 1. Bytes strobed while select is low are ignored, and deselect while idle produces no event.
- R9: `ev_trunc` is 1 when a read, page program or sector erase ends at deselect before byte 4. `ev_addr` then holds only the address bytes received, each in its own position, with zeros elsewhere.
- R10: Opcode 0x05 (read status) counts the status bytes the flash returns. `ev_resp[7:0]` holds the last of them, and the command ends at deselect.
- R11: Opcode 0x9F (read ID) captures the flash bytes at index 2, 3 and 4 into `ev_resp[23:16]`, `[15:8]` and `[7:0]`, then completes by itself.
- R12: Opcode 0x90 (manufacturer/device ID) ignores bytes 2 and 3. Bit 0 of host byte 4 sets the reply order: 0 means byte 5 is the manufacturer. The event carries the manufacturer in `ev_resp[15:8]` and the device in `[7:0]`, with `[23:16]` zero, and completes after byte 6.
- R13: The other known opcodes are 0x04, 0x01, 0x0B, 0xD8, 0x60, 0xC7, 0xB9 and 0xAB. They give class 8, count the bytes that follow the opcode, and end at deselect.
- R14: `ev_valid` is high for one cycle, in the cycle after the completing byte or after the first deselected cycle. Class codes are: write enable 1, read status 2, read 3, page program 4, sector erase 5, read ID 6, manufacturer/device ID 7, other known 8, unknown 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_active | input | 1 | High while the flash device is selected |
| byte_valid | input | 1 | One-cycle strobe marking a transferred byte pair |
| mosi_byte | input | 8 | Byte sent by the host |
| miso_byte | input | 8 | Byte returned by the flash |
| ev_valid | output | 1 | Event record valid for this cycle |
| ev_class | output | 4 | Command class code |
| ev_opcode | output | 8 | Raw opcode of the command |
| ev_addr | output | 24 | Assembled address |
| ev_count | output | CNT_W | Payload or status byte count |
| ev_resp | output | 24 | Captured ID or status bytes |
| ev_misalign | output | 1 | Sector erase address not 4096-aligned |
| ev_trunc | output | 1 | Address-bearing command ended before its address was complete |

## Verification
The assertions assume two things about the inputs. `cs_active` is a level that frames whole transactions, and `byte_valid` marks at most one byte pair per cycle. A strobe while select is low is treated as noise that must leave the state untouched. The bench drives inputs on the falling edge, with one idle cycle between bytes. It closes every transaction with a deselect lasting several cycles, so an event can never be hidden by the next opcode. Random unknown opcodes are drawn only from values outside the decode table. Transfer lengths are kept short, so page program reaches its natural end only in a directed case.

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;

  typedef enum logic [3:0] {
    CL_NONE    = 4'd0,
    CL_WREN    = 4'd1,
    CL_RDSR    = 4'd2,
    CL_READ    = 4'd3,
    CL_PP      = 4'd4,
    CL_SE      = 4'd5,
    CL_RDID    = 4'd6,
    CL_REMS    = 4'd7,
    CL_OTHER   = 4'd8,
    CL_UNKNOWN = 4'd9
  } mon_class_e;

  function automatic mon_class_e classify_op(input logic [7:0] op);
    mon_class_e c;
    case (op)
      8'h06: c = CL_WREN;
      8'h05: c = CL_RDSR;
      8'h03: c = CL_READ;
      8'h02: c = CL_PP;
      8'h20: c = CL_SE;
      8'h9F: c = CL_RDID;
      8'h90: c = CL_REMS;
      8'h04, 8'h01, 8'h0B, 8'hD8,
      8'h60, 8'hC7, 8'hB9, 8'hAB: c = CL_OTHER;
      default: c = CL_UNKNOWN;
    endcase
    return c;
  endfunction

  // slot 0 is the most significant byte of the 24-bit field
  function automatic logic [23:0] place_byte(input logic [23:0] cur,
                                             input logic [7:0]  b,
                                             input logic [1:0]  slot);
    logic [23:0] r;
    r = cur;
    case (slot)
      2'd0:    r[23:16] = b;
      2'd1:    r[15:8]  = b;
      default: r[7:0]   = b;
    endcase
    return r;
  endfunction

  function automatic logic carries_addr(input mon_class_e c);
    return (c == CL_READ) || (c == CL_PP) || (c == CL_SE);
  endfunction

  function automatic logic sector_misaligned(input logic [23:0] a);
    return a[11:0] != 12'h000;
  endfunction

  // result: [15:8] manufacturer, [7:0] device
  function automatic logic [23:0] id_order(input logic       dev_first,
                                           input logic [7:0] first_b,
                                           input logic [7:0] second_b);
    return dev_first ? {8'h00, second_b, first_b} : {8'h00, first_b, second_b};
  endfunction

endpackage

// File: rtl/spi_mon_opdec.sv
module spi_mon_opdec
  import spi_mon_pkg::*;
(
  input  logic [7:0]  op,
  output mon_class_e  cls,
  output logic        one_shot
);
  always_comb begin
    cls      = classify_op(op);
    one_shot = (cls == CL_WREN) || (cls == CL_UNKNOWN);
  end
endmodule

// File: rtl/spi_mon_seq.sv
module spi_mon_seq
  import spi_mon_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  parameter int CNT_W      = 16,
  parameter int IDX_W      = $clog2(PAGE_BYTES + 6) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_active,
  input  logic             byte_valid,
  input  logic [7:0]       mosi,
  input  logic [7:0]       miso,
  input  mon_class_e       op_cls,
  input  logic             op_one_shot,
  output logic             fire,
  output mon_class_e       f_cls,
  output logic [7:0]       f_op,
  output logic [23:0]      f_addr,
  output logic [CNT_W-1:0] f_cnt,
  output logic [23:0]      f_resp,
  output logic             f_misalign,
  output logic             f_trunc,
  output logic             opcode_take,
  output logic             fire_opcode,
  output logic             fire_natural,
  output logic             fire_abort,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] IX_ONE    = IDX_W'(1);
  localparam logic [IDX_W-1:0] IX_TWO    = IDX_W'(2);
  localparam logic [IDX_W-1:0] IX_FOUR   = IDX_W'(4);
  localparam logic [IDX_W-1:0] IX_FIVE   = IDX_W'(5);
  localparam logic [IDX_W-1:0] IX_SIX    = IDX_W'(6);
  localparam logic [IDX_W-1:0] IX_PP_END = IDX_W'(PAGE_BYTES + 4);

  logic             busy_q, swap_q;
  mon_class_e       cls_q;
  logic [7:0]       op_q, first_q;
  logic [IDX_W-1:0] idx_q, idx_inc;
  logic [23:0]      addr_q, resp_q, nxt_addr, nxt_resp;
  logic [CNT_W-1:0] cnt_q, cnt_inc, nxt_cnt;
  logic [7:0]       nxt_first;
  logic             nxt_swap, natural_end, data_take, in_addr, take;
  logic [1:0]       slot;

  assign take        = byte_valid & cs_active;
  assign opcode_take = take & ~busy_q;
  assign data_take   = take & busy_q;
  assign fire_abort  = ~cs_active & busy_q;
  assign fire_opcode = opcode_take & op_one_shot;
  assign busy_o      = busy_q;
  assign idx_o       = idx_q;

  assign idx_inc = (&idx_q) ? idx_q : idx_q + 1'b1;
  assign cnt_inc = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
  assign in_addr = (idx_q >= IX_TWO) && (idx_q <= IX_FOUR);
  assign slot    = idx_q[1:0] - 2'd2;

  // per-command byte sequencing
  always_comb begin
    nxt_addr    = addr_q;
    nxt_cnt     = cnt_q;
    nxt_resp    = resp_q;
    nxt_swap    = swap_q;
    nxt_first   = first_q;
    natural_end = 1'b0;
    if (data_take) begin
      case (cls_q)
        CL_RDSR: begin
          nxt_cnt  = cnt_inc;
          nxt_resp = {16'h0000, miso};
        end
        CL_READ: begin
          if (in_addr) nxt_addr = place_byte(addr_q, mosi, slot);
          else         nxt_cnt  = cnt_inc;
        end
        CL_PP: begin
          if (in_addr) nxt_addr = place_byte(addr_q, mosi, slot);
          else         nxt_cnt  = cnt_inc;
          natural_end = (idx_q == IX_PP_END);
        end
        CL_SE: begin
          if (in_addr) nxt_addr = place_byte(addr_q, mosi, slot);
          natural_end = (idx_q == IX_FOUR);
        end
        CL_RDID: begin
          if (in_addr) nxt_resp = place_byte(resp_q, miso, slot);
          natural_end = (idx_q == IX_FOUR);
        end
        CL_REMS: begin
          if (idx_q == IX_FOUR) nxt_swap  = mosi[0];
          if (idx_q == IX_FIVE) nxt_first = miso;
          if (idx_q == IX_SIX) begin
            nxt_resp    = id_order(swap_q, first_q, miso);
            natural_end = 1'b1;
          end
        end
        CL_OTHER: nxt_cnt = cnt_inc;
        default: ;
      endcase
    end
  end

  assign fire_natural = data_take & natural_end;
  assign fire         = fire_opcode | fire_natural | fire_abort;

  // event field selection
  always_comb begin
    if (fire_opcode) begin
      f_cls      = op_cls;
      f_op       = mosi;
      f_addr     = '0;
      f_cnt      = '0;
      f_resp     = '0;
      f_misalign = 1'b0;
      f_trunc    = 1'b0;
    end else begin
      f_cls      = cls_q;
      f_op       = op_q;
      f_addr     = nxt_addr;
      f_cnt      = nxt_cnt;
      f_resp     = nxt_resp;
      f_misalign = fire_natural && (cls_q == CL_SE) && sector_misaligned(nxt_addr);
      f_trunc    = fire_abort && carries_addr(cls_q) && (idx_q < IX_FIVE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cls_q   <= CL_NONE;
      op_q    <= '0;
      idx_q   <= IX_ONE;
      addr_q  <= '0;
      cnt_q   <= '0;
      resp_q  <= '0;
      swap_q  <= 1'b0;
      first_q <= '0;
    end else if (fire_abort) begin
      busy_q <= 1'b0;
      idx_q  <= IX_ONE;
    end else if (opcode_take && !op_one_shot) begin
      busy_q  <= 1'b1;
      cls_q   <= op_cls;
      op_q    <= mosi;
      idx_q   <= IX_TWO;
      addr_q  <= '0;
      cnt_q   <= '0;
      resp_q  <= '0;
      swap_q  <= 1'b0;
      first_q <= '0;
    end else if (data_take) begin
      addr_q  <= nxt_addr;
      cnt_q   <= nxt_cnt;
      resp_q  <= nxt_resp;
      swap_q  <= nxt_swap;
      first_q <= nxt_first;
      if (natural_end) begin
        busy_q <= 1'b0;
        idx_q  <= IX_ONE;
      end else begin
        idx_q <= idx_inc;
      end
    end
  end

  // R8: a deselected cycle always leaves the sequencer idle at index 1
  p_deselect_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> (!busy_o && idx_o == IX_ONE));

  // R8: idle always means the next byte is index 1
  p_idle_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> idx_o == IX_ONE);

  // R6: page program never reports more than a page
  p_pp_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && f_cls == CL_PP) |-> f_cnt <= CNT_W'(PAGE_BYTES));

  // R14: at most one way of ending a command per cycle
  p_one_end_r14: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fire_opcode, fire_natural, fire_abort}));

endmodule

// File: rtl/spi_mon_evreg.sv
module spi_mon_evreg
  import spi_mon_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  mon_class_e       f_cls,
  input  logic [7:0]       f_op,
  input  logic [23:0]      f_addr,
  input  logic [CNT_W-1:0] f_cnt,
  input  logic [23:0]      f_resp,
  input  logic             f_misalign,
  input  logic             f_trunc,
  output logic             ev_valid,
  output mon_class_e       ev_cls,
  output logic [7:0]       ev_op,
  output logic [23:0]      ev_addr,
  output logic [CNT_W-1:0] ev_cnt,
  output logic [23:0]      ev_resp,
  output logic             ev_misalign,
  output logic             ev_trunc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_valid    <= 1'b0;
      ev_cls      <= CL_NONE;
      ev_op       <= '0;
      ev_addr     <= '0;
      ev_cnt      <= '0;
      ev_resp     <= '0;
      ev_misalign <= 1'b0;
      ev_trunc    <= 1'b0;
    end else begin
      ev_valid <= fire;
      if (fire) begin
        ev_cls      <= f_cls;
        ev_op       <= f_op;
        ev_addr     <= f_addr;
        ev_cnt      <= f_cnt;
        ev_resp     <= f_resp;
        ev_misalign <= f_misalign;
        ev_trunc    <= f_trunc;
      end
    end
  end

  // R4: the alignment warning belongs only to a completed sector erase
  p_misalign_se_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_misalign) |-> (ev_cls == CL_SE && !ev_trunc));

  // R9: truncation only applies to address-bearing commands
  p_trunc_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_trunc) |-> carries_addr(ev_cls));

  // R14: fields hold steady between events
  p_fields_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(ev_addr) && $stable(ev_cls) && $stable(ev_cnt)));

endmodule

// File: rtl/spi_flash_cmd_monitor.sv
module spi_flash_cmd_monitor
  import spi_mon_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_active,
  input  logic             byte_valid,
  input  logic [7:0]       mosi_byte,
  input  logic [7:0]       miso_byte,
  output logic             ev_valid,
  output logic [3:0]       ev_class,
  output logic [7:0]       ev_opcode,
  output logic [23:0]      ev_addr,
  output logic [CNT_W-1:0] ev_count,
  output logic [23:0]      ev_resp,
  output logic             ev_misalign,
  output logic             ev_trunc
);
  localparam int IDX_W = $clog2(PAGE_BYTES + 6) + 1;

  mon_class_e       op_cls, f_cls, ev_cls_e;
  logic             op_one_shot, fire, f_misalign, f_trunc;
  logic [7:0]       f_op;
  logic [23:0]      f_addr, f_resp;
  logic [CNT_W-1:0] f_cnt;
  logic             opcode_take, fire_opcode, fire_natural, fire_abort, busy;
  logic [IDX_W-1:0] idx;

  spi_mon_opdec u_opdec (
    .op       (mosi_byte),
    .cls      (op_cls),
    .one_shot (op_one_shot)
  );

  spi_mon_seq #(.PAGE_BYTES(PAGE_BYTES), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_active    (cs_active),
    .byte_valid   (byte_valid),
    .mosi         (mosi_byte),
    .miso         (miso_byte),
    .op_cls       (op_cls),
    .op_one_shot  (op_one_shot),
    .fire         (fire),
    .f_cls        (f_cls),
    .f_op         (f_op),
    .f_addr       (f_addr),
    .f_cnt        (f_cnt),
    .f_resp       (f_resp),
    .f_misalign   (f_misalign),
    .f_trunc      (f_trunc),
    .opcode_take  (opcode_take),
    .fire_opcode  (fire_opcode),
    .fire_natural (fire_natural),
    .fire_abort   (fire_abort),
    .busy_o       (busy),
    .idx_o        (idx)
  );

  spi_mon_evreg #(.CNT_W(CNT_W)) u_ev (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .f_cls       (f_cls),
    .f_op        (f_op),
    .f_addr      (f_addr),
    .f_cnt       (f_cnt),
    .f_resp      (f_resp),
    .f_misalign  (f_misalign),
    .f_trunc     (f_trunc),
    .ev_valid    (ev_valid),
    .ev_cls      (ev_cls_e),
    .ev_op       (ev_opcode),
    .ev_addr     (ev_addr),
    .ev_cnt      (ev_count),
    .ev_resp     (ev_resp),
    .ev_misalign (ev_misalign),
    .ev_trunc    (ev_trunc)
  );

  assign ev_class = ev_cls_e;

  // R2: write enable is reported in the very next cycle
  p_wren_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode_take && op_cls == CL_WREN) |=> (ev_valid && ev_cls_e == CL_WREN));

  // R7: an unknown opcode is reported in the very next cycle
  p_unknown_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode_take && op_cls == CL_UNKNOWN) |=> (ev_valid && ev_cls_e == CL_UNKNOWN));

  // R8: a deselect during a command yields an event next cycle
  p_abort_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire_abort |=> ev_valid);

  // R14: the event strobe follows exactly the cycles that ended a command
  p_valid_source_r14: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire_opcode || fire_natural || fire_abort) |=> !ev_valid);

  // R1: nothing is in progress while idle at index 1
  p_idle_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    opcode_take |-> (!busy && idx == IDX_W'(1)));

endmodule

// File: tb/spi_flash_cmd_monitor_bench.sv
`timescale 1ns/1ps
module spi_flash_cmd_monitor_bench;
  localparam int PAGE_BYTES = 256;
  localparam int CNT_W      = 16;

  logic clk = 1'b0, rst_n = 1'b0, cs_active = 1'b0, byte_valid = 1'b0;
  logic [7:0] mosi_byte = 8'h00, miso_byte = 8'h00;
  logic             ev_valid, ev_misalign, ev_trunc;
  logic [3:0]       ev_class;
  logic [7:0]       ev_opcode;
  logic [23:0]      ev_addr, ev_resp;
  logic [CNT_W-1:0] ev_count;

  spi_flash_cmd_monitor #(.PAGE_BYTES(PAGE_BYTES), .CNT_W(CNT_W)) u_spi_flash_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .byte_valid(byte_valid),
    .mosi_byte(mosi_byte), .miso_byte(miso_byte), .ev_valid(ev_valid),
    .ev_class(ev_class), .ev_opcode(ev_opcode), .ev_addr(ev_addr),
    .ev_count(ev_count), .ev_resp(ev_resp), .ev_misalign(ev_misalign),
    .ev_trunc(ev_trunc)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, n_ev = 0;
  bit done = 1'b0;
  logic [3:0]  c_cls;
  logic [7:0]  c_op;
  logic [23:0] c_addr, c_resp;
  logic [31:0] c_cnt;
  logic        c_mis, c_trunc;
  logic [7:0]  mo [0:15];
  logic [7:0]  mi [0:15];

  always @(negedge clk) begin
    if (rst_n && ev_valid) begin
      n_ev++;
      c_cls = ev_class; c_op = ev_opcode; c_addr = ev_addr;
      c_cnt = 32'(ev_count); c_resp = ev_resp;
      c_mis = ev_misalign; c_trunc = ev_trunc;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_ev(input string tag, input int n0, input int cls, input logic [7:0] op,
                          input logic [23:0] addr, input int cnt, input logic [23:0] resp,
                          input bit mis, input bit trunc);
    check({tag, " event count"}, n_ev, n0 + 1);
    check({tag, " class"}, 32'(c_cls), cls);
    check({tag, " opcode"}, 32'(c_op), 32'(op));
    check({tag, " addr"}, 32'(c_addr), 32'(addr));
    check({tag, " count"}, c_cnt, cnt);
    check({tag, " resp"}, 32'(c_resp), 32'(resp));
    check({tag, " misalign"}, 32'(c_mis), 32'(mis));
    check({tag, " trunc"}, 32'(c_trunc), 32'(trunc));
  endtask

  task automatic xfer(input logic [7:0] mo_b, input logic [7:0] mi_b);
    @(negedge clk);
    cs_active = 1'b1; byte_valid = 1'b1; mosi_byte = mo_b; miso_byte = mi_b;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) xfer(mo[i], mi[i]);
  endtask

  task automatic deselect();
    @(negedge clk);
    cs_active = 1'b0;
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  function automatic bit known_op(input logic [7:0] b);
    logic [7:0] tbl [0:14];
    tbl = '{8'h06, 8'h05, 8'h03, 8'h02, 8'h20, 8'h9F, 8'h90, 8'h04,
            8'h01, 8'h0B, 8'hD8, 8'h60, 8'hC7, 8'hB9, 8'hAB};
    foreach (tbl[i]) if (tbl[i] == b) return 1'b1;
    return 1'b0;
  endfunction

  // address bytes received keep their position, the rest are zero
  function automatic logic [23:0] partial_addr(input logic [23:0] a, input int nrecv);
    logic [23:0] r;
    r = 24'h0;
    for (int k = 0; k < 3; k++) if (k < nrecv) r[23 - 8*k -: 8] = a[23 - 8*k -: 8];
    return r;
  endfunction

  function automatic int data_after_addr(input int nbytes);
    return (nbytes > 4) ? nbytes - 4 : 0;
  endfunction

  function automatic logic [23:0] id_pair(input logic sel, input logic [7:0] b5, input logic [7:0] b6);
    if (sel) return {8'h00, b6, b5};
    return {8'h00, b5, b6};
  endfunction

  task automatic fill_addr_cmd(input logic [7:0] op, input logic [23:0] a, input int n);
    mo[0] = op; mi[0] = 8'($urandom);
    mo[1] = a[23:16]; mo[2] = a[15:8]; mo[3] = a[7:0];
    for (int i = 1; i < 16; i++) begin
      if (i > 3) mo[i] = 8'($urandom);
      mi[i] = 8'($urandom);
    end
    send(n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n0, n, kind;
    logic [23:0] a;
    logic [7:0] op, sel, b5, b6, b2, b3, b4;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    check("R1 reset ev_valid", 32'(ev_valid), 0);
    check("R1 no event at reset", n_ev, 0);

    // R1/R2: first selected byte is an opcode; pulse lasts one cycle (R14)
    n0 = n_ev;
    xfer(8'h06, 8'h00);
    #1;
    check("R14 ev_valid high after byte", 32'(ev_valid), 1);
    settle();
    check("R14 ev_valid single cycle", 32'(ev_valid), 0);
    check_ev("R2 wren", n0, 1, 8'h06, 24'h0, 0, 24'h0, 0, 0);

    // R2: next byte in same select is a new opcode (read here, R3/R5)
    n0 = n_ev;
    mo[0] = 8'h03; mo[1] = 8'hA1; mo[2] = 8'hB2; mo[3] = 8'hC3;
    mo[4] = 8'h00; mo[5] = 8'h00;
    mi[4] = 8'h11; mi[5] = 8'h22;
    send(6);
    deselect();
    check_ev("R2 R3 R5 read after wren", n0, 3, 8'h03, 24'hA1B2C3, 2, 24'h0, 0, 0);

    // R8: strobe with select low is ignored; deselect while idle gives nothing
    n0 = n_ev;
    @(negedge clk); cs_active = 1'b0; byte_valid = 1'b1; mosi_byte = 8'h06;
    @(negedge clk); byte_valid = 1'b0;
    deselect();
    check("R8 deselected strobe ignored", n_ev, n0);
    n0 = n_ev;
    xfer(8'h03, 8'h00);
    deselect();
    check_ev("R8 R9 opcode-only read", n0, 3, 8'h03, 24'h0, 0, 24'h0, 0, 1);

    // R4: aligned and misaligned sector erase
    n0 = n_ev; fill_addr_cmd(8'h20, 24'h003000, 4); deselect();
    check_ev("R4 aligned erase", n0, 5, 8'h20, 24'h003000, 0, 24'h0, 0, 0);
    n0 = n_ev; fill_addr_cmd(8'h20, 24'h003001, 4); deselect();
    check_ev("R4 misaligned erase", n0, 5, 8'h20, 24'h003001, 0, 24'h0, 1, 0);

    // R6: full page ends by itself, then next byte is a new opcode
    n0 = n_ev;
    xfer(8'h02, 8'h00); xfer(8'h00, 8'h00); xfer(8'h11, 8'h00); xfer(8'h00, 8'h00);
    for (int i = 0; i < PAGE_BYTES; i++) xfer(8'(i), 8'h00);
    settle();
    check_ev("R6 full page", n0, 4, 8'h02, 24'h001100, PAGE_BYTES, 24'h0, 0, 0);
    n0 = n_ev;
    xfer(8'h06, 8'h00);
    deselect();
    check_ev("R6 byte after page is opcode", n0, 1, 8'h06, 24'h0, 0, 24'h0, 0, 0);

    // R12: both reply orders
    n0 = n_ev;
    mo[0] = 8'h90; mo[1] = 8'h00; mo[2] = 8'h00; mo[3] = 8'h00; mo[4] = 8'h00; mo[5] = 8'h00;
    mi[4] = 8'hC2; mi[5] = 8'h15;
    send(6); deselect();
    check_ev("R12 manufacturer first", n0, 7, 8'h90, 24'h0, 0, 24'h00C215, 0, 0);
    n0 = n_ev;
    mo[3] = 8'h01; mi[4] = 8'h15; mi[5] = 8'hC2;
    send(6); deselect();
    check_ev("R12 device first", n0, 7, 8'h90, 24'h0, 0, 24'h00C215, 0, 0);

    // R7: unknown opcode
    n0 = n_ev; xfer(8'h55, 8'h00); deselect();
    check_ev("R7 unknown", n0, 9, 8'h55, 24'h0, 0, 24'h0, 0, 0);

    // random mix
    for (int it = 0; it < 300; it++) begin
      kind = $urandom_range(0, 8);
      n0 = n_ev;
      case (kind)
        0: begin
          xfer(8'h06, 8'($urandom)); deselect();
          check_ev("R2 rand wren", n0, 1, 8'h06, 24'h0, 0, 24'h0, 0, 0);
        end
        1: begin
          a = 24'($urandom); n = $urandom_range(1, 9);
          fill_addr_cmd(8'h03, a, n); deselect();
          check_ev("R3 R5 R9 rand read", n0, 3, 8'h03, partial_addr(a, n - 1),
                   data_after_addr(n), 24'h0, 0, n < 4);
        end
        2: begin
          a = 24'($urandom); n = $urandom_range(1, 9);
          fill_addr_cmd(8'h02, a, n); deselect();
          check_ev("R3 R6 R9 rand program", n0, 4, 8'h02, partial_addr(a, n - 1),
                   data_after_addr(n), 24'h0, 0, n < 4);
        end
        3: begin
          a = 24'($urandom);
          if ($urandom_range(0, 1) == 0) a[11:0] = 12'h000;
          n = ($urandom_range(0, 1) == 0) ? 4 : $urandom_range(1, 3);
          fill_addr_cmd(8'h20, a, n); deselect();
          check_ev("R4 R9 rand erase", n0, 5, 8'h20, partial_addr(a, n - 1), 0, 24'h0,
                   (n == 4) && (a[11:0] != 12'h000), n < 4);
        end
        4: begin
          b2 = 8'($urandom); b3 = 8'($urandom); b4 = 8'($urandom);
          xfer(8'h9F, 8'h00); xfer(8'($urandom), b2); xfer(8'($urandom), b3); xfer(8'($urandom), b4);
          deselect();
          check_ev("R11 rand read id", n0, 6, 8'h9F, 24'h0, 0, {b2, b3, b4}, 0, 0);
        end
        5: begin
          sel = 8'($urandom); b5 = 8'($urandom); b6 = 8'($urandom);
          xfer(8'h90, 8'h00); xfer(8'($urandom), 8'($urandom)); xfer(8'($urandom), 8'($urandom));
          xfer(sel, 8'($urandom)); xfer(8'($urandom), b5); xfer(8'($urandom), b6);
          deselect();
          check_ev("R12 rand ids", n0, 7, 8'h90, 24'h0, 0, id_pair(sel[0], b5, b6), 0, 0);
        end
        6: begin
          n = $urandom_range(1, 4);
          mo[0] = 8'h05;
          for (int i = 0; i < 16; i++) begin
            if (i > 0) mo[i] = 8'($urandom);
            mi[i] = 8'($urandom);
          end
          send(n); deselect();
          check_ev("R10 rand status", n0, 2, 8'h05, 24'h0, n - 1,
                   (n > 1) ? {16'h0, mi[n - 1]} : 24'h0, 0, 0);
        end
        7: begin
          case ($urandom_range(0, 7))
            0: op = 8'h04; 1: op = 8'h01; 2: op = 8'h0B; 3: op = 8'hD8;
            4: op = 8'h60; 5: op = 8'hC7; 6: op = 8'hB9; default: op = 8'hAB;
          endcase
          n = $urandom_range(1, 4);
          mo[0] = op;
          for (int i = 1; i < 16; i++) begin mo[i] = 8'($urandom); mi[i] = 8'($urandom); end
          send(n); deselect();
          check_ev("R13 rand other", n0, 8, op, 24'h0, n - 1, 24'h0, 0, 0);
        end
        default: begin
          op = 8'($urandom);
          while (known_op(op)) op = 8'($urandom);
          xfer(op, 8'($urandom)); deselect();
          check_ev("R7 rand unknown", n0, 9, op, 24'h0, 0, 24'h0, 0, 0);
        end
      endcase
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule